// File: doc/BRIEF.md
# Two-Way Memory Port Unit

This block sits between the data path of a microcoded processor and a single byte-addressed memory. It makes that memory look like two logical ports. One is a word port that reads and writes 32-bit values. Its address comes from a word-address register and its data passes through a word-data register. The other is a read-only byte port that fetches instruction bytes. Its address comes from a fetch-pointer register, and each fetched byte lands in a byte register.

The data path loads the three address and data registers from its result bus (the C bus) under per-register load enables. It reads any one of the registers back through the operand bus (the B bus). The fetched byte can be placed on the B bus in two 32-bit forms: zero-filled or sign-filled. The block turns word addresses into byte addresses. It arbitrates the single memory between the two ports and delivers read data with a fixed latency, so microcode can count cycles instead of polling.

The memory behind the unit is synchronous. It samples a request at a clock edge and presents read data during the following cycle. A word is stored little-endian: the byte at the lowest address sits in bits 7:0.

Top module: `mem_port_unit`

## Requirements
- R1: After reset, the word-address, word-data, fetch-pointer and fetched-byte registers are all zero.
- R2: When `ld_waddr`, `ld_wdata` or `ld_fptr` is high in a cycle, the matching register takes `c_bus` at the end of that cycle and shows the new value on `b_bus` from the next cycle on.
- R3: `b_bus` carries the register selected by the single high output enable. `oe_byte_u` gives the fetched byte with bits 31:8 zero. `oe_byte_s` gives the fetched byte with bit 7 copied into bits 31:8. With no enable high, `b_bus` is zero.
- R4: For a word request, `mem_addr` equals the word address shifted left by two. The top two word-address bits are lost and `mem_addr[1:0]` is zero. A word address loaded in the same cycle is the one used, so word address 2 gives byte address 8.
- R5: A granted word read drives `mem_rd`=1 and `mem_byte`=0 in its issue cycle N. The word-data register takes `mem_rdata` at the end of cycle N+1, and the new value is readable on `b_bus` in cycle N+2 and not before.
- R6: A granted byte fetch drives `mem_rd`=1 and `mem_byte`=1, and uses the fetch pointer (or the value being loaded into it) as `mem_addr`. It never drives `mem_wr`. It places `mem_rdata[7:0]` in the fetched-byte register with the same N+1 / N+2 timing as R5.
- R7: A granted word write drives `mem_wr`=1 with `mem_wdata` equal to the word-data register (or the value being loaded into it) and the R4 address. Reading that word back returns all four bytes, and fetching the four byte addresses returns them in little-endian order.
- R8: Only one read can be pending. Any new request in cycle N+1 discards the delivery of a read issued in cycle N, so two back-to-back fetches leave the fetched-byte register holding the second byte, never the first.
- R9: When requests collide in one cycle, a write beats a word read, which beats a fetch. A losing request is ignored and leaves its destination register unchanged.
- R10: When a word-data load from `c_bus` and a word-read delivery fall in the same cycle, the `c_bus` value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_bus | input | 32 | Result bus from the data path |
| ld_waddr | input | 1 | Load word-address register from `c_bus` |
| ld_wdata | input | 1 | Load word-data register from `c_bus` |
| ld_fptr | input | 1 | Load fetch-pointer register from `c_bus` |
| oe_waddr | input | 1 | Drive word address onto `b_bus` |
| oe_wdata | input | 1 | Drive word data onto `b_bus` |
| oe_fptr | input | 1 | Drive fetch pointer onto `b_bus` |
| oe_byte_u | input | 1 | Drive fetched byte, zero-filled, onto `b_bus` |
| oe_byte_s | input | 1 | Drive fetched byte, sign-filled, onto `b_bus` |
| rd_word | input | 1 | Request a word read |
| wr_word | input | 1 | Request a word write |
| fetch_byte | input | 1 | Request a byte fetch |
| b_bus | output | 32 | Operand bus value |
| mem_addr | output | 32 | Byte address to memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe (four bytes) |
| mem_byte | output | 1 | Read is a single byte into `mem_rdata[7:0]` |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_rdata | input | 32 | Read data, valid in the cycle after the request |

## Verification
The hardest case to reach from the ports is a pending read being overtaken by a newer request before its data lands. The first and second results are easy to tell apart only if the register shows neither value in between. The stimulus issues two fetches in consecutive cycles to addresses whose bytes differ from each other and from the byte already held. It then reads the byte register in the cycle where the first byte would have appeared, and again one cycle later. Collisions are produced the same way: a fetch is issued in the same cycle as a write or a word read, and the byte register is then confirmed to be unchanged after the full latency.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_WORD = 2'd1,
      PEND_BYTE = 2'd2
   } pend_e;

   function automatic int unsigned log2_ceil(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/mpu_addr_map.sv
module mpu_addr_map #(
   parameter int ADDR_W = 32,
   parameter int SHIFT  = 2
) (
   input  logic [ADDR_W-1:0] word_addr,
   output logic [ADDR_W-1:0] byte_addr
);

   generate
      if (SHIFT == 0) begin : g_flat
         assign byte_addr = word_addr;
      end else begin : g_scaled
         // the upper SHIFT bits fall off the top; the low SHIFT lines read zero
         assign byte_addr = word_addr << SHIFT;
      end
   endgenerate

endmodule

// File: rtl/mpu_req_arb.sv
module mpu_req_arb
   import mpu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_word,
   input  logic wr_word,
   input  logic fetch_byte,
   output logic mem_rd,
   output logic mem_wr,
   output logic mem_byte,
   output logic dlv_word,
   output logic dlv_byte
);

   logic  grant_wr, grant_rd, grant_fetch, any_req;
   pend_e pend_q, pend_n;

   // fixed priority: write, then word read, then fetch
   assign grant_wr    = wr_word;
   assign grant_rd    = rd_word & ~wr_word;
   assign grant_fetch = fetch_byte & ~wr_word & ~rd_word;
   assign any_req     = rd_word | wr_word | fetch_byte;

   assign mem_wr   = grant_wr;
   assign mem_rd   = grant_rd | grant_fetch;
   assign mem_byte = grant_fetch;

   always_comb begin
      if (grant_rd)         pend_n = PEND_WORD;
      else if (grant_fetch) pend_n = PEND_BYTE;
      else                  pend_n = PEND_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= PEND_NONE;
      else        pend_q <= pend_n;
   end

   // a newer request supersedes the read still in flight
   assign dlv_word = (pend_q == PEND_WORD) & ~any_req;
   assign dlv_byte = (pend_q == PEND_BYTE) & ~any_req;

endmodule

// File: rtl/mpu_bdrive.sv
module mpu_bdrive #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] fptr,
   input  logic [BYTE_W-1:0] fbyte,
   input  logic              oe_waddr,
   input  logic              oe_wdata,
   input  logic              oe_fptr,
   input  logic              oe_byte_u,
   input  logic              oe_byte_s,
   output logic [DATA_W-1:0] b_bus
);

   localparam int FILL_W = DATA_W - BYTE_W;

   logic [DATA_W-1:0] byte_zx, byte_sx;

   generate
      if (FILL_W == 0) begin : g_no_fill
         assign byte_zx = fbyte;
         assign byte_sx = fbyte;
      end else begin : g_fill
         assign byte_zx = {{FILL_W{1'b0}}, fbyte};
         assign byte_sx = {{FILL_W{fbyte[BYTE_W-1]}}, fbyte};
      end
   endgenerate

   always_comb begin
      b_bus = '0;
      if (oe_waddr)  b_bus = b_bus | waddr;
      if (oe_wdata)  b_bus = b_bus | wdata;
      if (oe_fptr)   b_bus = b_bus | fptr;
      if (oe_byte_u) b_bus = b_bus | byte_zx;
      if (oe_byte_s) b_bus = b_bus | byte_sx;
   end

endmodule

// File: rtl/mem_port_unit.sv
module mem_port_unit #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] c_bus,
   input  logic              ld_waddr,
   input  logic              ld_wdata,
   input  logic              ld_fptr,
   input  logic              oe_waddr,
   input  logic              oe_wdata,
   input  logic              oe_fptr,
   input  logic              oe_byte_u,
   input  logic              oe_byte_s,
   input  logic              rd_word,
   input  logic              wr_word,
   input  logic              fetch_byte,
   output logic [DATA_W-1:0] b_bus,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_byte,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int WORD_BYTES = DATA_W / BYTE_W;
   localparam int SHIFT      = mpu_pkg::log2_ceil(WORD_BYTES);

   generate
      if ((DATA_W % BYTE_W) != 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_lanes
         $error("word width must be a power-of-two multiple of the byte width");
      end
      if (ADDR_W != DATA_W) begin : g_bad_addr
         $error("address registers travel on the data buses, so ADDR_W must equal DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] waddr_q, waddr_n, fptr_q, fptr_n, word_byte_addr;
   logic [DATA_W-1:0] wdata_q, wdata_ld, wdata_n;
   logic [BYTE_W-1:0] fbyte_q, fbyte_n;
   logic              dlv_word, dlv_byte;

   // values as they will be at the end of this cycle: requests use these
   assign waddr_n  = ld_waddr ? c_bus : waddr_q;
   assign fptr_n   = ld_fptr  ? c_bus : fptr_q;
   assign wdata_ld = ld_wdata ? c_bus : wdata_q;
   assign wdata_n  = ld_wdata ? c_bus : (dlv_word ? mem_rdata : wdata_q);
   assign fbyte_n  = dlv_byte ? mem_rdata[BYTE_W-1:0] : fbyte_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waddr_q <= '0;
         wdata_q <= '0;
         fptr_q  <= '0;
         fbyte_q <= '0;
      end else begin
         waddr_q <= waddr_n;
         wdata_q <= wdata_n;
         fptr_q  <= fptr_n;
         fbyte_q <= fbyte_n;
      end
   end

   mpu_addr_map #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_map (
      .word_addr (waddr_n),
      .byte_addr (word_byte_addr)
   );

   mpu_req_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_word    (rd_word),
      .wr_word    (wr_word),
      .fetch_byte (fetch_byte),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_byte   (mem_byte),
      .dlv_word   (dlv_word),
      .dlv_byte   (dlv_byte)
   );

   mpu_bdrive #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bdrv (
      .waddr     (waddr_q),
      .wdata     (wdata_q),
      .fptr      (fptr_q),
      .fbyte     (fbyte_q),
      .oe_waddr  (oe_waddr),
      .oe_wdata  (oe_wdata),
      .oe_fptr   (oe_fptr),
      .oe_byte_u (oe_byte_u),
      .oe_byte_s (oe_byte_s),
      .b_bus     (b_bus)
   );

   assign mem_addr  = mem_byte ? fptr_n : word_byte_addr;
   assign mem_wdata = wdata_ld;

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              oe_waddr,
   input logic              oe_wdata,
   input logic              oe_fptr,
   input logic              oe_byte_u,
   input logic              oe_byte_s,
   input logic              rd_word,
   input logic              wr_word,
   input logic              fetch_byte,
   input logic [DATA_W-1:0] b_bus,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_byte
);

   logic [4:0] oe_vec;
   assign oe_vec = {oe_waddr, oe_wdata, oe_fptr, oe_byte_u, oe_byte_s};

   p_idle_bus_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_vec == 5'b0) |-> (b_bus == '0));

   p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_vec == 5'b00010) |-> (b_bus[DATA_W-1:BYTE_W] == '0));

   p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_vec == 5'b00001) |->
         (b_bus[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){b_bus[BYTE_W-1]}}));

   p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || (mem_rd && !mem_byte)) |-> (mem_addr[1:0] == 2'b00));

   p_fetch_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_byte |-> (mem_rd && !mem_wr));

   p_write_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_word |-> (mem_wr && !mem_rd));

   p_read_over_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word && !wr_word) |-> (mem_rd && !mem_byte));

   p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_word || wr_word || fetch_byte) |-> (!mem_rd && !mem_wr));

   p_fetch_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_byte && !rd_word && !wr_word) |-> mem_byte);

endmodule

bind mem_port_unit mpu_checker #(
   .DATA_W (DATA_W),
   .BYTE_W (BYTE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .oe_waddr   (oe_waddr),
   .oe_wdata   (oe_wdata),
   .oe_fptr    (oe_fptr),
   .oe_byte_u  (oe_byte_u),
   .oe_byte_s  (oe_byte_s),
   .rd_word    (rd_word),
   .wr_word    (wr_word),
   .fetch_byte (fetch_byte),
   .b_bus      (b_bus),
   .mem_addr   (mem_addr),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .mem_byte   (mem_byte)
);

// File: tb/sim_mem_port_unit.sv
`timescale 1ns/1ps
module sim_mem_port_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] c_bus = '0;
   logic        ld_waddr = 0, ld_wdata = 0, ld_fptr = 0;
   logic        oe_waddr = 0, oe_wdata = 0, oe_fptr = 0, oe_byte_u = 0, oe_byte_s = 0;
   logic        rd_word = 0, wr_word = 0, fetch_byte = 0;
   logic [31:0] b_bus, mem_addr, mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_rd, mem_wr, mem_byte;

   int n_chk = 0;
   int n_bad = 0;
   logic chk_en = 1'b0;
   logic [31:0] q_exp[$];
   string       q_tag[$];
   bit          finished = 0;

   always #2.5 clk = ~clk;

   mem_port_unit u0 (
      .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
      .ld_waddr(ld_waddr), .ld_wdata(ld_wdata), .ld_fptr(ld_fptr),
      .oe_waddr(oe_waddr), .oe_wdata(oe_wdata), .oe_fptr(oe_fptr),
      .oe_byte_u(oe_byte_u), .oe_byte_s(oe_byte_s),
      .rd_word(rd_word), .wr_word(wr_word), .fetch_byte(fetch_byte),
      .b_bus(b_bus), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_byte(mem_byte), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // ---------------- memory model ----------------
   function automatic logic [7:0] ib(input int a);
      return 8'((a & 255) * 37 + 11);
   endfunction

   function automatic logic [31:0] iw(input int a);
      return {ib(a + 3), ib(a + 2), ib(a + 1), ib(a)};
   endfunction

   function automatic logic [31:0] sx8(input logic [7:0] b);
      return {{24{b[7]}}, b};
   endfunction

   logic [7:0] mem [0:255];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= ib(i);
         mem_rdata <= '0;
      end else begin
         if (mem_wr)
            for (int k = 0; k < 4; k++) mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
         if (mem_rd)
            mem_rdata <= mem_byte ? {24'b0, mem[mem_addr[7:0]]}
                                  : {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                                     mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
      end
   end

   // ---------------- checking ----------------
   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard items and compares b_bus mid-cycle
   always @(negedge clk) begin
      if (chk_en) begin
         if (q_exp.size() == 0) cmp("scoreboard underrun", 32'h1, 32'h0);
         else cmp(q_tag.pop_front(), b_bus, q_exp.pop_front());
      end
   end

   // driver helpers
   task automatic tick();
      @(posedge clk);
      #0.5;
      {ld_waddr, ld_wdata, ld_fptr} = '0;
      {oe_waddr, oe_wdata, oe_fptr, oe_byte_u, oe_byte_s} = '0;
      {rd_word, wr_word, fetch_byte} = '0;
      chk_en = 1'b0;
   endtask

   task automatic expect_b(input int sel, input logic [31:0] exp, input string tag);
      case (sel)
         1: oe_waddr  = 1'b1;
         2: oe_wdata  = 1'b1;
         3: oe_fptr   = 1'b1;
         4: oe_byte_u = 1'b1;
         5: oe_byte_s = 1'b1;
         default: ;
      endcase
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      chk_en = 1'b1;
   endtask

   task automatic load(input int which, input logic [31:0] v);
      c_bus = v;
      case (which)
         1: ld_waddr = 1'b1;
         2: ld_wdata = 1'b1;
         default: ld_fptr = 1'b1;
      endcase
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state through every source
      expect_b(1, 32'h0, "R1 word address"); tick();
      expect_b(2, 32'h0, "R1 word data");    tick();
      expect_b(3, 32'h0, "R1 fetch pointer"); tick();
      expect_b(4, 32'h0, "R1 fetched byte");  tick();
      expect_b(0, 32'h0, "R3 no enable");     tick();

      // R2: loads from the C bus
      load(1, 32'h1234_5678); tick();
      expect_b(1, 32'h1234_5678, "R2 word address"); tick();
      load(2, 32'hCAFE_F00D); tick();
      expect_b(2, 32'hCAFE_F00D, "R2 word data"); tick();
      load(3, 32'h0000_0021); tick();
      expect_b(3, 32'h0000_0021, "R2 fetch pointer"); tick();

      // R4 + R5: word read at word address 2 loaded the same cycle
      load(1, 32'd2); rd_word = 1'b1; settle();
      cmp("R4 word 2 -> byte 8", mem_addr, 32'd8);
      cmp("R5 strobes", {29'b0, mem_rd, mem_wr, mem_byte}, 32'b100);
      tick();
      expect_b(2, 32'hCAFE_F00D, "R5 data not early"); tick();
      expect_b(2, iw(8), "R5 data lands"); tick();

      // R4: top bits dropped
      load(1, 32'hC000_0003); rd_word = 1'b1; settle();
      cmp("R4 top bits dropped", mem_addr, 32'h0000_000C);
      tick(); tick();
      expect_b(2, iw(12), "R5 read word 3"); tick();

      // R6 + R3: fetch of a negative byte
      load(3, 32'd5); fetch_byte = 1'b1; settle();
      cmp("R6 fetch address", mem_addr, 32'd5);
      cmp("R6 strobes", {29'b0, mem_rd, mem_wr, mem_byte}, 32'b101);
      tick();
      expect_b(4, 32'h0, "R6 byte not early"); tick();
      expect_b(4, {24'b0, ib(5)}, "R6 R3 zero-filled"); tick();
      expect_b(5, sx8(ib(5)), "R3 sign-filled negative"); tick();
      load(3, 32'd2); fetch_byte = 1'b1; tick(); tick();
      expect_b(5, {24'b0, ib(2)}, "R3 sign-filled positive"); tick();

      // R7: little-endian write and readback
      load(1, 32'd3); tick();
      load(2, 32'hA1B2_C3D4); wr_word = 1'b1; settle();
      cmp("R7 write strobe", {31'b0, mem_wr}, 32'd1);
      cmp("R7 write address", mem_addr, 32'd12);
      cmp("R7 write data", mem_wdata, 32'hA1B2_C3D4);
      tick();
      load(2, 32'h0); tick();
      rd_word = 1'b1; tick(); tick();
      expect_b(2, 32'hA1B2_C3D4, "R7 word readback"); tick();
      for (int k = 0; k < 4; k++) begin
         logic [31:0] w;
         w = 32'hA1B2_C3D4;
         load(3, 32'(12 + k)); fetch_byte = 1'b1; tick(); tick();
         expect_b(4, {24'b0, w[8*k +: 8]}, $sformatf("R7 byte lane %0d", k)); tick();
      end

      // R8: back-to-back fetches, newest wins (held byte is 0xA1)
      load(3, 32'd6); fetch_byte = 1'b1; tick();
      load(3, 32'd9); fetch_byte = 1'b1; tick();
      expect_b(4, 32'h0000_00A1, "R8 first fetch discarded"); tick();
      expect_b(4, {24'b0, ib(9)}, "R8 second fetch lands"); tick();

      // R9: write beats fetch
      load(3, 32'd7); fetch_byte = 1'b1; wr_word = 1'b1; settle();
      cmp("R9 write wins strobes", {29'b0, mem_rd, mem_wr, mem_byte}, 32'b010);
      tick(); tick();
      expect_b(4, {24'b0, ib(9)}, "R9 fetch under write ignored"); tick();

      // R9: word read beats fetch
      load(1, 32'd2); rd_word = 1'b1; fetch_byte = 1'b1; settle();
      cmp("R9 read wins strobes", {29'b0, mem_rd, mem_wr, mem_byte}, 32'b100);
      tick(); tick();
      expect_b(4, {24'b0, ib(9)}, "R9 fetch under read ignored"); tick();
      expect_b(2, iw(8), "R9 winning read delivered"); tick();

      // R10: C-bus load beats read delivery
      rd_word = 1'b1; tick();
      load(2, 32'h600D_F00D); tick();
      expect_b(2, 32'h600D_F00D, "R10 C bus kept"); tick();
      expect_b(2, 32'h600D_F00D, "R10 still kept"); tick();

      tick();
      summary();
   end

endmodule